// File: doc/BRIEF.md
# External single-port SRAM FIFO controller

This block builds a deep first-in first-out buffer on an external asynchronous single-port SRAM. Bytes arrive from a serial receiver that runs on its own baud-rate clock. Its write strobe and data cross into the FIFO clock through a two-flop synchroniser. Each rising edge of the strobe captures one word and raises a write request. A consumer in the FIFO clock domain asks for words by pulsing a read request.

Because the memory has a single port, an arbiter state machine runs one access at a time. Each access takes two cycles and is followed by one turnaround cycle. When both sides are waiting, the arbiter alternates between them. Fill level, full and empty come from a single up/hold/down occupancy counter. They do not come from a comparison of pointers. The read and write addresses are separate pointers that wrap at the depth of the memory.

Top module: `sram_fifo_ctrl`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `level`=0 and `rd_valid`=0, and all three SRAM strobes (`sram_ce_n`, `sram_we_n`, `sram_oe_n`) are high.
- R2: Words come out on `rd_data` in the order they were written. Each granted read gives exactly one `rd_valid` pulse, one cycle long.
- R3: `level` goes up by one for each completed write and down by one for each completed read. It never moves by more than one in a cycle. `full` is 1 when `level` equals 2^ADDR_W, and `empty` is 1 when `level` is 0.
- R4: A write request that arrives while the FIFO is full is dropped. `level` does not change, and the dropped word never appears at the output.
- R5: A read request made while the FIFO is empty is dropped. No SRAM read takes place and `rd_valid` stays 0.
- R6: `sram_we_n` and `sram_oe_n` are never low at the same time.
- R7: A write holds `sram_ce_n` low for two cycles, with `sram_we_n` high in the first cycle and low in the second. A read holds `sram_ce_n` and `sram_oe_n` low for two cycles.
- R8: Consecutive changes of `level` are at least four FIFO clock cycles apart.
- R9: One rising edge of `uart_wr_strobe` causes exactly one write, however long the strobe stays high.
- R10: The address pointers wrap modulo 2^ADDR_W. Order is preserved after the FIFO has been filled and drained more than once around the memory.
- R11: When a write and a read are both pending at the same time, the arbiter first grants the kind of operation it did not grant last. Log: the first access is a write if the previous grant was a read, and a read if the previous grant was a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FIFO clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| uart_wr_strobe | input | 1 | Write strobe from the serial receiver domain (asynchronous) |
| uart_wr_data | input | DATA_W | Receiver data, stable around the strobe's rising edge |
| rd_req | input | 1 | One-cycle read request from the consumer |
| rd_data | output | DATA_W | Word read from the FIFO |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| level | output | ADDR_W+1 | Current number of stored words |
| full | output | 1 | Level equals 2^ADDR_W |
| empty | output | 1 | Level equals zero |
| sram_addr | output | ADDR_W | SRAM address |
| sram_dq | inout | DATA_W | SRAM bidirectional data bus |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |

## Verification
The hardest case to reach is a write and a read that become pending in the same idle cycle, because that is the only way to see the alternating priority. The write request surfaces only after three synchroniser stages. The bench therefore raises the strobe and then times a one-cycle read pulse so that it lands on the same edge that sets the write request. It does this once after a read grant and once after a write grant, and compares the order of the resulting SRAM accesses. A reduced address width lets the bench fill the memory completely, try an overflow write, and drain across the pointer wrap.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_SETUP,
    ST_WR_STROBE,
    ST_RD_SETUP,
    ST_RD_SAMPLE,
    ST_TURN
  } acc_state_t;
endpackage

// File: rtl/sfifo_wsync.sv
module sfifo_wsync #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_async,
  input  logic [DATA_W-1:0] data_async,
  input  logic              take,
  output logic              pend,
  output logic [DATA_W-1:0] pend_data
);
  logic [2:0]        sync_q;
  logic              rise;
  logic              pend_nx;
  logic [DATA_W-1:0] data_q;

  assign rise = sync_q[1] & ~sync_q[2];

  always_comb begin
    pend_nx = pend;
    if (take)  pend_nx = 1'b0;
    if (rise)  pend_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      pend   <= 1'b0;
      data_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], strobe_async};
      pend   <= pend_nx;
      if (rise) data_q <= data_async;
    end
  end

  assign pend_data = data_q;
endmodule

// File: rtl/sfifo_level.sv
module sfifo_level #(
  parameter int ADDR_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up,
  input  logic            down,
  output logic [ADDR_W:0] level,
  output logic            full,
  output logic            empty
);
  localparam int LVL_W = ADDR_W + 1;
  localparam logic [LVL_W-1:0] FULL_LVL = {1'b1, {ADDR_W{1'b0}}};

  logic [LVL_W-1:0] cnt_q;
  logic [LVL_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (up && !down)      cnt_nx = cnt_q + 1'b1;
    else if (down && !up) cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign level = cnt_q;
  assign full  = (cnt_q == FULL_LVL);
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/sfifo_arb.sv
module sfifo_arb
  import sfifo_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_pend,
  input  logic [DATA_W-1:0] wr_word,
  output logic              wr_take,
  input  logic              rd_req,
  input  logic              full,
  input  logic              empty,
  output logic              cnt_up,
  output logic              cnt_down,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              bus_drive,
  output logic [DATA_W-1:0] bus_out,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  acc_state_t        st_q, st_nx;
  logic [ADDR_W-1:0] wptr_q, rptr_q;
  logic [DATA_W-1:0] wbuf_q, rdat_q;
  logic              rpend_q, rpend_nx;
  logic              favor_rd_q;
  logic              rvalid_q;
  logic              wr_ok, rd_ok;
  logic              grant_wr, grant_rd;

  assign wr_ok = wr_pend & ~full;
  assign rd_ok = rpend_q & ~empty;

  always_comb begin
    grant_wr = 1'b0;
    grant_rd = 1'b0;
    if (st_q == ST_IDLE) begin
      if (wr_ok && rd_ok) begin
        grant_rd = favor_rd_q;
        grant_wr = ~favor_rd_q;
      end else begin
        grant_wr = wr_ok;
        grant_rd = rd_ok;
      end
    end
  end

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (grant_wr)      st_nx = ST_WR_SETUP;
        else if (grant_rd) st_nx = ST_RD_SETUP;
      end
      ST_WR_SETUP:  st_nx = ST_WR_STROBE;
      ST_WR_STROBE: st_nx = ST_TURN;
      ST_RD_SETUP:  st_nx = ST_RD_SAMPLE;
      ST_RD_SAMPLE: st_nx = ST_TURN;
      default:      st_nx = ST_IDLE;
    endcase
  end

  // refused requests are dropped at the idle decision point
  assign wr_take = (st_q == ST_IDLE) & wr_pend & (full | grant_wr);

  always_comb begin
    rpend_nx = rpend_q;
    if ((st_q == ST_IDLE) && rpend_q && (empty || grant_rd)) rpend_nx = 1'b0;
    if (rd_req) rpend_nx = 1'b1;
  end

  assign cnt_up   = (st_q == ST_WR_STROBE);
  assign cnt_down = (st_q == ST_RD_SAMPLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      wptr_q     <= '0;
      rptr_q     <= '0;
      wbuf_q     <= '0;
      rdat_q     <= '0;
      rpend_q    <= 1'b0;
      favor_rd_q <= 1'b0;
      rvalid_q   <= 1'b0;
    end else begin
      st_q     <= st_nx;
      rpend_q  <= rpend_nx;
      rvalid_q <= cnt_down;
      if (grant_wr || grant_rd) favor_rd_q <= grant_wr;
      if (grant_wr)             wbuf_q     <= wr_word;
      if (cnt_up)               wptr_q     <= wptr_q + 1'b1;
      if (cnt_down) begin
        rptr_q <= rptr_q + 1'b1;
        rdat_q <= bus_in;
      end
    end
  end

  assign mem_ce_n  = ~((st_q == ST_WR_SETUP) | (st_q == ST_WR_STROBE) |
                       (st_q == ST_RD_SETUP) | (st_q == ST_RD_SAMPLE));
  assign mem_we_n  = ~(st_q == ST_WR_STROBE);
  assign mem_oe_n  = ~((st_q == ST_RD_SETUP) | (st_q == ST_RD_SAMPLE));
  assign mem_addr  = ((st_q == ST_RD_SETUP) || (st_q == ST_RD_SAMPLE)) ? rptr_q : wptr_q;
  assign bus_drive = (st_q == ST_WR_STROBE);
  assign bus_out   = wbuf_q;
  assign rd_data   = rdat_q;
  assign rd_valid  = rvalid_q;
endmodule

// File: rtl/sram_fifo_ctrl.sv
module sram_fifo_ctrl #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uart_wr_strobe,
  input  logic [DATA_W-1:0] uart_wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W:0]   level,
  output logic              full,
  output logic              empty,
  output logic [ADDR_W-1:0] sram_addr,
  inout  wire  [DATA_W-1:0] sram_dq,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              wr_pend, wr_take;
  logic [DATA_W-1:0] wr_word;
  logic              cnt_up, cnt_down;
  logic              bus_drive;
  logic [DATA_W-1:0] bus_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sfifo_wsync #(.DATA_W(DATA_W)) u_wsync (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .strobe_async (uart_wr_strobe),
    .data_async   (uart_wr_data),
    .take         (wr_take),
    .pend         (wr_pend),
    .pend_data    (wr_word)
  );

  sfifo_level #(.ADDR_W(ADDR_W)) u_level (
    .clk   (clk),
    .rst_n (rst_int_n),
    .up    (cnt_up),
    .down  (cnt_down),
    .level (level),
    .full  (full),
    .empty (empty)
  );

  sfifo_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_pend   (wr_pend),
    .wr_word   (wr_word),
    .wr_take   (wr_take),
    .rd_req    (rd_req),
    .full      (full),
    .empty     (empty),
    .cnt_up    (cnt_up),
    .cnt_down  (cnt_down),
    .mem_addr  (sram_addr),
    .mem_ce_n  (sram_ce_n),
    .mem_we_n  (sram_we_n),
    .mem_oe_n  (sram_oe_n),
    .bus_drive (bus_drive),
    .bus_out   (bus_out),
    .bus_in    (sram_dq),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  assign sram_dq = bus_drive ? bus_out : {DATA_W{1'bz}};
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int ADDR_W = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ce_n,
  input logic            we_n,
  input logic            oe_n,
  input logic [ADDR_W:0] level,
  input logic            full,
  input logic            empty,
  input logic            rd_valid
);
  logic [ADDR_W:0] prev_lvl_q;
  logic [2:0]      since_q;
  logic            lvl_chg;

  assign lvl_chg = (level != prev_lvl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl_q <= '0;
      since_q    <= 3'd7;
    end else begin
      prev_lvl_q <= level;
      if (lvl_chg)            since_q <= 3'd1;
      else if (since_q != 3'd7) since_q <= since_q + 3'd1;
    end
  end

  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));

  assert_we_setup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(!ce_n && we_n && oe_n));

  assert_we_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> we_n);

  assert_oe_two_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |=> !oe_n);

  assert_oe_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && $past(!oe_n)) |=> oe_n);

  assert_level_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (level != $past(level)) |-> ((level == $past(level) + 1'b1) || (level + 1'b1 == $past(level))));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> we_n);

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> oe_n);

  assert_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_chg |-> (since_q >= 3'd4));

  assert_valid_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!oe_n));
endmodule

bind sram_fifo_ctrl sfifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (sram_ce_n),
  .we_n     (sram_we_n),
  .oe_n     (sram_oe_n),
  .level    (level),
  .full     (full),
  .empty    (empty),
  .rd_valid (rd_valid)
);

// File: tb/sram_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module sram_fifo_ctrl_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          strobe;
  logic [DW-1:0] wdata;
  logic          rd_req;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic [AW:0]   level;
  logic          full, empty;
  logic [AW-1:0] sram_addr;
  wire  [DW-1:0] sram_dq;
  logic          sram_ce_n, sram_we_n, sram_oe_n;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sram_fifo_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .uart_wr_strobe(strobe), .uart_wr_data(wdata),
    .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid), .level(level),
    .full(full), .empty(empty), .sram_addr(sram_addr), .sram_dq(sram_dq),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
  );

  // SRAM model
  logic [DW-1:0] mem [0:DEPTH-1];
  logic [DW-1:0] mdrv;
  logic          mdrv_en;
  assign sram_dq = mdrv_en ? mdrv : {DW{1'bz}};

  always @(negedge clk) begin
    if (!sram_ce_n && !sram_we_n) mem[sram_addr] = sram_dq;
    mdrv_en = !sram_ce_n && !sram_oe_n;
    mdrv    = mem[sram_addr];
  end

  // access monitor: operation log, access shape (R7), level spacing (R8), excl (R6)
  byte oplog[$];
  logic prev_ce_n = 1'b1;
  int   run_len = 0;
  logic run_is_wr = 1'b0;
  logic run_bad = 1'b0;
  int   shape_viol = 0;
  int   excl_viol = 0;
  int   gap_viol = 0;
  int   since_chg = 100;
  logic [AW:0] prev_level = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!sram_we_n && !sram_oe_n) excl_viol++;
      if (!sram_ce_n) begin
        if (prev_ce_n) begin
          run_len = 1;
          run_is_wr = sram_oe_n;
          oplog.push_back(sram_oe_n ? "W" : "R");
          run_bad = run_is_wr ? !sram_we_n : sram_oe_n;
        end else begin
          run_len++;
          if (run_is_wr && sram_we_n) run_bad = 1'b1;
          if (!run_is_wr && sram_oe_n) run_bad = 1'b1;
        end
      end else if (!prev_ce_n) begin
        if (run_len != 2 || run_bad) shape_viol++;
      end
      prev_ce_n = sram_ce_n;
      if (level != prev_level) begin
        if (since_chg < 4) gap_viol++;
        since_chg = 1;
      end else begin
        since_chg++;
      end
      prev_level = level;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic uart_wr(input logic [DW-1:0] d, input int hold);
    @(posedge clk); #1;
    wdata = d;
    strobe = 1'b1;
    repeat (hold) @(posedge clk);
    #1 strobe = 1'b0;
    repeat (10) @(posedge clk);
  endtask

  task automatic read_one(output logic [DW-1:0] d, output int pulses);
    @(posedge clk); #1 rd_req = 1'b1;
    @(posedge clk); #1 rd_req = 1'b0;
    pulses = 0;
    d = '0;
    repeat (10) begin
      @(negedge clk);
      if (rd_valid) begin
        pulses++;
        d = rd_data;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(empty == 1'b1, "R1 empty", empty, 1);
    check(full == 1'b0, "R1 full", full, 0);
    check(level == '0, "R1 level", level, 0);
    check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    check({sram_ce_n, sram_we_n, sram_oe_n} == 3'b111, "R1 strobes",
          {sram_ce_n, sram_we_n, sram_oe_n}, 7);
  endtask

  task automatic t_empty_read();
    logic [DW-1:0] d;
    int p, n;
    n = oplog.size();
    read_one(d, p);
    check(p == 0, "R5 rd_valid on empty", p, 0);
    check(oplog.size() == n, "R5 no sram read", oplog.size(), n);
    check(level == '0, "R5 level", level, 0);
  endtask

  task automatic t_basic();
    logic [DW-1:0] d;
    int p;
    uart_wr(8'h11, 1);
    uart_wr(8'h22, 2);
    uart_wr(8'h33, 1);
    @(negedge clk);
    check(level == 3, "R3 level after 3 writes", level, 3);
    read_one(d, p);
    check(p == 1, "R2 single pulse", p, 1);
    check(d == 8'h11, "R2 first word", d, 8'h11);
    check(level == 2, "R3 level after read", level, 2);
    read_one(d, p);
    check(d == 8'h22, "R2 second word", d, 8'h22);
    read_one(d, p);
    check(d == 8'h33, "R2 third word", d, 8'h33);
    check(empty == 1'b1, "R3 empty after drain", empty, 1);
  endtask

  task automatic t_long_strobe();
    logic [DW-1:0] d;
    int p;
    uart_wr(8'h5A, 25);
    @(negedge clk);
    check(level == 1, "R9 one write per strobe edge", level, 1);
    read_one(d, p);
    check(d == 8'h5A, "R9 data", d, 8'h5A);
  endtask

  task automatic t_fill_wrap();
    logic [DW-1:0] d;
    int p;
    for (int i = 0; i < DEPTH; i++) uart_wr(DW'(8'h40 + i), 1);
    @(negedge clk);
    check(full == 1'b1, "R3 full", full, 1);
    check(level == DEPTH, "R3 level at full", level, DEPTH);
    uart_wr(8'hEE, 1);
    @(negedge clk);
    check(level == DEPTH, "R4 level unchanged on overflow", level, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      read_one(d, p);
      check(d == DW'(8'h40 + i) && p == 1, "R4 R10 drain order", d, 8'h40 + i);
    end
    check(empty == 1'b1, "R3 empty after full drain", empty, 1);
    for (int i = 0; i < 5; i++) uart_wr(DW'(8'hA0 + i), 1);
    for (int i = 0; i < 5; i++) begin
      read_one(d, p);
      check(d == DW'(8'hA0 + i), "R10 order after wrap", d, 8'hA0 + i);
    end
  endtask

  task automatic contest(input logic [DW-1:0] d, input byte first, input logic [DW-1:0] exp_rd);
    int n;
    int p;
    logic [DW-1:0] got;
    n = oplog.size();
    @(posedge clk); #1;
    wdata = d;
    strobe = 1'b1;
    @(posedge clk);
    @(posedge clk); #1 rd_req = 1'b1;
    @(posedge clk); #1 rd_req = 1'b0;
    strobe = 1'b0;
    p = 0;
    got = '0;
    repeat (14) begin
      @(negedge clk);
      if (rd_valid) begin
        p++;
        got = rd_data;
      end
    end
    check(oplog.size() == n + 2, "R11 two accesses", oplog.size(), n + 2);
    if (oplog.size() >= n + 2)
      check(oplog[n] == first, "R11 first grant", oplog[n], first);
    check(p == 1 && got == exp_rd, "R11 read data", got, exp_rd);
  endtask

  task automatic t_priority();
    logic [DW-1:0] d;
    int p;
    uart_wr(8'hC1, 1);
    uart_wr(8'hC2, 1);
    read_one(d, p);                 // last grant: read
    contest(8'hD1, "W", 8'hC2);     // write first
    uart_wr(8'hD2, 1);              // last grant: write
    contest(8'hD3, "R", 8'hD1);     // read first
    read_one(d, p);
    check(d == 8'hD2, "R11 R2 remaining order", d, 8'hD2);
    read_one(d, p);
    check(d == 8'hD3, "R11 R2 last word", d, 8'hD3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    strobe = 1'b0;
    wdata = '0;
    rd_req = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_empty_read();
    t_basic();
    t_long_strobe();
    t_fill_wrap();
    t_priority();
    check(shape_viol == 0, "R7 access shape", shape_viol, 0);
    check(excl_viol == 0, "R6 strobe exclusion", excl_viol, 0);
    check(gap_viol == 0, "R8 level spacing", gap_viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule